// File: doc/BRIEF.md
# Serial Peripheral Interface Controller with Completion and Collision Flags

This block connects an 8-bit register bus to a four-wire synchronous serial link. It can act as either the clock-driving end (master) or the clock-following end (slave), and it moves one 8-bit frame per transfer in SPI mode 0: the clock idles low, each bit is presented after a falling edge, and each bit is captured while the clock is high. In master mode the serial clock is derived from the block clock by a divider. Three rate bits select the divider, and the third of them picks a set of faster dividers.

Software writes the data register to start a master frame, or to preload the reply of a slave frame. It learns that a frame has ended from a completion flag, which can also drive an interrupt request. A write to the data register while a frame is in progress raises a collision flag and is otherwise dropped. Both flags are cleared by a two-step handshake: a status read that sees the flag set, then a data-register access. The completion flag can also be cleared by an interrupt acknowledge. A master whose select pin is configured as an input and is pulled low gives up the bus. It returns to slave mode, abandons the frame in progress and reports the event through the completion flag.

Top module: `spi_ctrl`

## Requirements
- R1: After reset, the control, status and data registers read 0x00, `sck_o` is low, `master_o` is low and `irq_o` is low.
- R2: The master SCK period in block clocks is selected by {status bit 0, control bits 1:0} as follows: 000=4, 001=16, 010=64, 011=128, 100=2, 101=8, 110=32, 111=64. If the data write that starts a frame is taken at clock edge E, the first SCK rise comes at E+period/2. The clock makes eight full periods and idles low. The completion flag sets at E+8*period.
- R3: Bus addresses are 0 control, 1 status and 2 data. Control bit 7 is interrupt enable, bit 6 block enable, bit 5 LSB-first and bit 4 master select. By default frames go MSB first. At the end of a frame, reading the data register returns the byte received from the other end.
- R4: With control bit 5 set, both ends shift the frame LSB first and the bytes still arrive intact.
- R5: In slave mode (bit 6 set, bit 4 clear, `ss_ni` low), the block receives the frame from `sck_i`/`mosi_i` and returns its preloaded byte on `miso_o`, whatever the value of control bits 1:0. SCK may be at most the block clock divided by 4. The pins pass through a 2-stage synchronizer, so the completion flag sets 3 clocks after the final SCK fall at the pin.
- R6: A data-register write during a frame sets status bit 6 (collision) and is discarded. The frame in progress carries its original byte.
- R7: A data-register access (read or write) clears only those flags that were set at the most recent status read. A flag that was not set when the status register was read survives the data access.
- R8: A flag set event in the same clock as its handshake clear leaves the flag set.
- R9: `irq_o` is high exactly while status bit 7 (completion), control bit 7 and `gie_i` are all high. `irq_ack_i` clears the completion flag.
- R10: When the block is in master mode with `ss_in_i` high and `ss_ni` is pulled low, control bit 4 clears, `master_o` and `sck_o` go low, the frame is aborted and status bit 7 sets.
- R11: Status bits 5:1 always read 0. Status bit 0 is read/write.
- R12: With control bit 6 clear, a data-register write starts no frame and `sck_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| irq_o | output | 1 | Interrupt request |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears completion flag |
| gie_i | input | 1 | Global interrupt enable |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| master_o | output | 1 | High while the block drives SCK and MOSI |
| mosi_i | input | 1 | Serial data in (slave) |
| mosi_o | output | 1 | Serial data out (master) |
| miso_i | input | 1 | Serial data in (master) |
| miso_o | output | 1 | Serial data out (slave) |
| ss_ni | input | 1 | Select pin level, active low |
| ss_in_i | input | 1 | Select pin is configured as an input |

## Verification
The completion of a slave frame can fall in the same clock as the data-register read that clears the completion flag. To provoke it, the slave's flag is first armed with a status read. A master frame at the fastest slave-safe rate is then started, and the slave data read is issued so that it commits exactly 8*period+3 clocks after the start edge. The status read that follows must still show the flag set. A design that lets the clear win reports it clear.

// File: rtl/spi_pkg.sv
package spi_pkg;
  parameter int DATA_W = 8;
  parameter int ADDR_W = 2;
  parameter int SYNC_N = 2;
  parameter int DIV_W  = 7;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

  typedef struct packed {
    logic       ie;
    logic       en;
    logic       lsb;
    logic       mstr;
    logic [1:0] rsv;
    logic [1:0] rate;
  } ctrl_t;

  localparam logic [7:0] CTRL_MASK = 8'hF3;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          STAGES  = 2,
  parameter int          WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] q_prev_o
);
  logic [WIDTH-1:0] st_q [STAGES+1];

  for (genvar i = 0; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    st_q[i] <= RST_VAL;
      else if (i == 0) st_q[i] <= d_i;
      else            st_q[i] <= st_q[i-1];
    end
  end

  assign q_o      = st_q[STAGES-1];
  assign q_prev_o = st_q[STAGES];
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int DIV_W = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       dbl_i,
  input  logic [1:0] rate_i,
  output logic       tick_o
);
  logic [2:0]       lg;
  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] cnt_q;

  // lg = log2(sck period in clocks)
  always_comb begin
    unique case (rate_i)
      2'd0:    lg = 3'd2;
      2'd1:    lg = 3'd4;
      2'd2:    lg = 3'd6;
      default: lg = 3'd7;
    endcase
    lg   = lg - {2'b00, dbl_i};
    half = DIV_W'(1) << (lg - 3'd1);
  end

  assign tick_o = run_i && (cnt_q == half - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/spi_shift.sv
module spi_shift
  import spi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              master_i,
  input  logic              lsb_i,
  input  logic              tick_i,
  input  logic              abort_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              miso_i,
  input  logic              ss_ni,
  output logic              run_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              sck_o,
  output logic              sdo_o,
  output logic              ss_lvl_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sck_q, mbusy_q, sframe_q, lat_q;
  logic [2:0]        syn, syn_prev;
  logic              sck_s, mosi_s, ss_s, s_rise, s_fall, s_act, in_bit;
  logic              m_last, s_last;

  spi_sync #(.STAGES(SYNC_N), .WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     ({ss_ni, sck_i, mosi_i}),
    .q_o     (syn),
    .q_prev_o(syn_prev)
  );

  assign ss_s   = syn[2];
  assign sck_s  = syn[1];
  assign mosi_s = syn[0];
  assign s_rise = sck_s & ~syn_prev[1];
  assign s_fall = ~sck_s & syn_prev[1];
  assign s_act  = en_i & ~master_i & ~ss_s;

  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] v,
                                                 input logic b, input logic lsb);
    return lsb ? {b, v[DATA_W-1:1]} : {v[DATA_W-2:0], b};
  endfunction

  assign in_bit = master_i ? miso_i : lat_q;
  assign rx_o   = shift_in(sh_q, in_bit, lsb_i);
  assign m_last = en_i & master_i & mbusy_q & ~abort_i & tick_i & sck_q & (cnt_q == LAST);
  assign s_last = s_act & sframe_q & s_fall & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0; cnt_q <= '0; sck_q <= 1'b0;
      mbusy_q <= 1'b0; sframe_q <= 1'b0; lat_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0; sck_q <= 1'b0; mbusy_q <= 1'b0; sframe_q <= 1'b0;
    end else if (master_i) begin
      sframe_q <= 1'b0;
      if (abort_i) begin
        mbusy_q <= 1'b0; sck_q <= 1'b0; cnt_q <= '0;
      end else if (!mbusy_q) begin
        sck_q <= 1'b0;
        cnt_q <= '0;
        if (load_i) begin
          sh_q    <= load_data_i;
          mbusy_q <= 1'b1;
        end
      end else if (tick_i) begin
        if (!sck_q) sck_q <= 1'b1;
        else begin
          // late capture: miso sampled at the end of the high phase
          sck_q <= 1'b0;
          sh_q  <= rx_o;
          if (cnt_q == LAST) begin
            cnt_q   <= '0;
            mbusy_q <= 1'b0;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end else begin
      mbusy_q <= 1'b0;
      sck_q   <= 1'b0;
      if (!s_act) begin
        sframe_q <= 1'b0;
        cnt_q    <= '0;
      end else if (s_rise) begin
        lat_q    <= mosi_s;
        sframe_q <= 1'b1;
      end else if (s_fall && sframe_q) begin
        sh_q <= rx_o;
        if (cnt_q == LAST) begin
          cnt_q    <= '0;
          sframe_q <= 1'b0;
        end else cnt_q <= cnt_q + CNT_W'(1);
      end
      if (load_i && !sframe_q) sh_q <= load_data_i;
    end
  end

  assign run_o    = mbusy_q;
  assign busy_o   = mbusy_q | sframe_q;
  assign done_o   = m_last | s_last;
  assign sck_o    = sck_q;
  assign sdo_o    = lsb_i ? sh_q[0] : sh_q[DATA_W-1];
  assign ss_lvl_o = ss_s;
endmodule

// File: rtl/spi_flags.sv
module spi_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic modf_i,
  input  logic coll_i,
  input  logic stat_rd_i,
  input  logic data_acc_i,
  input  logic ack_i,
  output logic tc_o,
  output logic wcol_o
);
  logic arm_tc_q, arm_wcol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_o <= 1'b0; wcol_o <= 1'b0; arm_tc_q <= 1'b0; arm_wcol_q <= 1'b0;
    end else begin
      if (stat_rd_i) begin
        arm_tc_q   <= tc_o;
        arm_wcol_q <= wcol_o;
      end else if (data_acc_i) begin
        arm_tc_q   <= 1'b0;
        arm_wcol_q <= 1'b0;
      end
      // later assignments win: set beats clear
      if ((data_acc_i && arm_tc_q) || ack_i) tc_o <= 1'b0;
      if (done_i || modf_i)                  tc_o <= 1'b1;
      if (data_acc_i && arm_wcol_q)          wcol_o <= 1'b0;
      if (coll_i)                            wcol_o <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o,
  input  logic              irq_ack_i,
  input  logic              gie_i,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              master_o,
  input  logic              mosi_i,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              miso_o,
  input  logic              ss_ni,
  input  logic              ss_in_i
);
  ctrl_t             ctrl_q;
  logic              dbl_q;
  logic [DATA_W-1:0] rxbuf_q, rx;
  logic              sel_ctrl, sel_stat, sel_data;
  logic              tick, run, busy, done, sdo, ss_lvl, modf, coll, load;
  logic              tc, wcol;

  assign sel_ctrl = addr_i == A_CTRL;
  assign sel_stat = addr_i == A_STAT;
  assign sel_data = addr_i == A_DATA;

  assign modf = ctrl_q.en & ctrl_q.mstr & ss_in_i & ~ss_lvl;
  assign coll = wr_i & sel_data & busy;
  assign load = wr_i & sel_data & ~busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      dbl_q   <= 1'b0;
      rxbuf_q <= '0;
    end else begin
      if (wr_i && sel_ctrl) ctrl_q <= ctrl_t'(wdata_i & CTRL_MASK);
      if (wr_i && sel_stat) dbl_q  <= wdata_i[0];
      if (modf)             ctrl_q.mstr <= 1'b0;
      if (done)             rxbuf_q <= rx;
    end
  end

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .dbl_i (dbl_q),
    .rate_i(ctrl_q.rate),
    .tick_o(tick)
  );

  spi_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl_q.en),
    .master_i   (ctrl_q.mstr),
    .lsb_i      (ctrl_q.lsb),
    .tick_i     (tick),
    .abort_i    (modf),
    .load_i     (load),
    .load_data_i(wdata_i),
    .sck_i      (sck_i),
    .mosi_i     (mosi_i),
    .miso_i     (miso_i),
    .ss_ni      (ss_ni),
    .run_o      (run),
    .busy_o     (busy),
    .done_o     (done),
    .rx_o       (rx),
    .sck_o      (sck_o),
    .sdo_o      (sdo),
    .ss_lvl_o   (ss_lvl)
  );

  spi_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done),
    .modf_i    (modf),
    .coll_i    (coll),
    .stat_rd_i (rd_i & sel_stat),
    .data_acc_i((rd_i | wr_i) & sel_data),
    .ack_i     (irq_ack_i),
    .tc_o      (tc),
    .wcol_o    (wcol)
  );

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = ctrl_q;
      A_STAT:  rdata_o = {tc, wcol, 5'b0, dbl_q};
      A_DATA:  rdata_o = rxbuf_q;
      default: rdata_o = 8'h00;
    endcase
  end

  assign irq_o    = tc & ctrl_q.ie & gie_i;
  assign master_o = ctrl_q.en & ctrl_q.mstr;
  assign mosi_o   = sdo;
  assign miso_o   = sdo;
endmodule

// File: rtl/spi_ctrl_chk.sv
module spi_ctrl_chk
  import spi_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        rdata_i,
  input logic              irq_i,
  input logic              gie_i,
  input logic              ack_i,
  input logic              sck_i,
  input logic              master_i,
  input logic              tc_i,
  input logic              wcol_i,
  input logic              busy_i,
  input logic              done_i,
  input logic              modf_i
);
  assert_stat_view_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_STAT) |-> (rdata_i[7] == tc_i && rdata_i[6] == wcol_i && rdata_i[5:1] == 5'b0));

  assert_sck_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !sck_i);

  assert_coll_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_DATA && busy_i) |=> wcol_i);

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> tc_i);

  assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (gie_i && tc_i));

  assert_ack_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !done_i && !modf_i) |=> !tc_i);

  assert_modf_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    modf_i |=> (!master_i && tc_i && !busy_i && !sck_i));
endmodule

bind spi_ctrl spi_ctrl_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .rdata_i (rdata_o),
  .irq_i   (irq_o),
  .gie_i   (gie_i),
  .ack_i   (irq_ack_i),
  .sck_i   (sck_o),
  .master_i(master_o),
  .tc_i    (tc),
  .wcol_i  (wcol),
  .busy_i  (busy),
  .done_i  (done),
  .modf_i  (modf)
);

// File: tb/sim_spi_ctrl.sv
`timescale 1ns/1ps
module sim_spi_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0] m_addr = '0, s_addr = '0;
  logic       m_wr = 0, m_rd = 0, s_wr = 0, s_rd = 0;
  logic [7:0] m_wd = '0, s_wd = '0, m_rdata, s_rdata;
  logic       m_irq, s_irq, m_ack = 0, s_ack = 0, gie = 1;
  logic       m_sck, m_master, m_mosi, m_miso_nc, s_sck_nc, s_master, s_mosi_nc, s_miso;
  logic       m_ss_n = 1, m_ss_in = 0, s_ss_n = 1;

  int checks = 0, fails = 0;
  bit ended = 0;

  localparam logic [1:0] CTRL = 2'd0, STAT = 2'd1, DATA = 2'd2;

  spi_ctrl u0 (.clk_i(clk), .rst_ni(rst_n), .addr_i(m_addr), .wr_i(m_wr), .rd_i(m_rd),
    .wdata_i(m_wd), .rdata_o(m_rdata), .irq_o(m_irq), .irq_ack_i(m_ack), .gie_i(gie),
    .sck_i(1'b0), .sck_o(m_sck), .master_o(m_master), .mosi_i(1'b0), .mosi_o(m_mosi),
    .miso_i(s_miso), .miso_o(m_miso_nc), .ss_ni(m_ss_n), .ss_in_i(m_ss_in));

  spi_ctrl u1 (.clk_i(clk), .rst_ni(rst_n), .addr_i(s_addr), .wr_i(s_wr), .rd_i(s_rd),
    .wdata_i(s_wd), .rdata_o(s_rdata), .irq_o(s_irq), .irq_ack_i(s_ack), .gie_i(gie),
    .sck_i(m_sck), .sck_o(s_sck_nc), .master_o(s_master), .mosi_i(m_mosi), .mosi_o(s_mosi_nc),
    .miso_i(1'b0), .miso_o(s_miso), .ss_ni(s_ss_n), .ss_in_i(1'b0));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int dev, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    if (dev == 0) begin m_addr = a; m_wd = d; m_wr = 1; end
    else          begin s_addr = a; s_wd = d; s_wr = 1; end
    @(posedge clk);
    @(negedge clk);
    m_wr = 0; s_wr = 0;
  endtask

  task automatic rd(input int dev, input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    if (dev == 0) begin m_addr = a; m_rd = 1; end
    else          begin s_addr = a; s_rd = 1; end
    #1 d = (dev == 0) ? m_rdata : s_rdata;
    @(posedge clk);
    @(negedge clk);
    m_rd = 0; s_rd = 0;
  endtask

  task automatic clear_flags(input int dev);
    logic [7:0] d;
    rd(dev, STAT, d);
    rd(dev, DATA, d);
  endtask

  task automatic wait_irq0(input int limit);
    int n = 0;
    while (!m_irq && n < limit) begin @(negedge clk); n++; end
  endtask

  function automatic int period_of(input int code);
    int base;
    case (code & 3)
      0: base = 4; 1: base = 16; 2: base = 64; default: base = 128;
    endcase
    return base >> ((code >> 2) & 1);
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    rd(0, CTRL, d); chk("R1 ctrl", d, 0);
    rd(0, STAT, d); chk("R1 stat", d, 0);
    rd(0, DATA, d); chk("R1 data", d, 0);
    chk("R1 sck/irq/master", {m_sck, m_irq, m_master}, 0);
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    wr(0, STAT, 8'hFF); rd(0, STAT, d); chk("R11 stat ones", d, 8'h01);
    wr(0, STAT, 8'h00); rd(0, STAT, d); chk("R11 stat zero", d, 8'h00);
  endtask

  task automatic t_dividers();
    for (int code = 0; code < 8; code++) begin
      int p, n, r1, r2;
      logic prev;
      p = period_of(code);
      wr(0, CTRL, 8'hD0 | 8'(code & 3));
      wr(0, STAT, 8'(code >> 2));
      wr(0, DATA, 8'h96);
      n = 0; r1 = -1; r2 = -1; prev = m_sck;
      while (!m_irq && n < 2000) begin
        @(negedge clk); n++;
        if (m_sck && !prev) begin
          if (r1 < 0) r1 = n; else if (r2 < 0) r2 = n;
        end
        prev = m_sck;
      end
      chk($sformatf("R2 first rise code%0d", code), r1, p / 2);
      chk($sformatf("R2 period code%0d", code), r2 - r1, p);
      chk($sformatf("R2 frame length code%0d", code), n, 8 * p);
      chk("R2 sck idle", m_sck, 0);
      @(negedge clk); m_ack = 1; @(negedge clk); m_ack = 0;
    end
    wr(0, STAT, 8'h00);
  endtask

  task automatic t_xfer(input int code, input logic [7:0] mb, input logic [7:0] sb,
                        input bit lsb);
    logic [7:0] d;
    wr(0, CTRL, 8'hD0 | (8'(lsb) << 5) | 8'(code & 3));
    wr(0, STAT, 8'(code >> 2));
    wr(1, CTRL, 8'h43 | (8'(lsb) << 5));
    wr(1, DATA, sb);
    s_ss_n = 0;
    repeat (4) @(negedge clk);
    wr(0, DATA, mb);
    wait_irq0(3000);
    repeat (6) @(negedge clk);
    rd(0, DATA, d); chk(lsb ? "R4 master rx" : "R3 master rx", d, sb);
    rd(1, DATA, d); chk(lsb ? "R4 slave rx" : "R5 slave rx", d, mb);
    rd(1, STAT, d); chk("R5 slave done flag", d, 8'h80);
    rd(1, DATA, d);
    clear_flags(0);
    s_ss_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    wr(0, CTRL, 8'hD0); wr(0, STAT, 8'h00);
    wr(1, CTRL, 8'h40); wr(1, DATA, 8'h5A);
    s_ss_n = 0; repeat (4) @(negedge clk);
    wr(0, DATA, 8'hC3);
    repeat (5) @(negedge clk);
    wr(0, DATA, 8'h11);
    rd(0, STAT, d); chk("R6 collision flag", d, 8'h40);
    wait_irq0(3000);
    repeat (6) @(negedge clk);
    rd(1, DATA, d); chk("R6 frame kept", d, 8'hC3);
    rd(0, DATA, d); chk("R3 master rx after collision", d, 8'h5A);
    rd(0, STAT, d); chk("R7 only armed flag cleared", d, 8'h80);
    rd(0, DATA, d);
    rd(0, STAT, d); chk("R7 handshake clears", d, 8'h00);
    clear_flags(1);
    s_ss_n = 1; repeat (4) @(negedge clk);
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    wr(0, CTRL, 8'hD0); wr(0, STAT, 8'h00);
    wr(1, CTRL, 8'h40); wr(1, DATA, 8'h00);
    s_ss_n = 0; repeat (4) @(negedge clk);
    wr(0, DATA, 8'h24);
    wait_irq0(3000);
    repeat (6) @(negedge clk);
    clear_flags(0);
    rd(1, STAT, d); chk("R8 slave flag armed", d, 8'h80);
    wr(0, DATA, 8'h99);
    repeat (8 * 4 + 2) @(negedge clk);
    s_addr = DATA; s_rd = 1;
    @(posedge clk); @(negedge clk); s_rd = 0;
    rd(1, STAT, d); chk("R8 set beats clear", d, 8'h80);
    rd(1, DATA, d); chk("R5 slave rx 2nd frame", d, 8'h99);
    rd(1, STAT, d); chk("R7 slave cleared", d, 8'h00);
    clear_flags(0);
    s_ss_n = 1; repeat (4) @(negedge clk);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr(0, CTRL, 8'hD0); wr(0, DATA, 8'h01);
    wait_irq0(3000);
    chk("R9 irq set", m_irq, 1);
    @(negedge clk); gie = 0; #1 chk("R9 gie gates", m_irq, 0);
    @(negedge clk); gie = 1; #1 chk("R9 gie restored", m_irq, 1);
    wr(0, CTRL, 8'h50); chk("R9 ie gates", m_irq, 0);
    wr(0, CTRL, 8'hD0); chk("R9 ie restored", m_irq, 1);
    @(negedge clk); m_ack = 1; @(negedge clk); m_ack = 0;
    chk("R9 ack clears irq", m_irq, 0);
    rd(0, STAT, d); chk("R9 ack clears flag", d, 8'h00);
  endtask

  task automatic t_mode_fault();
    logic [7:0] d;
    wr(0, CTRL, 8'h50); m_ss_in = 1;
    wr(0, DATA, 8'hF0);
    repeat (3) @(negedge clk);
    m_ss_n = 0;
    repeat (6) @(negedge clk);
    chk("R10 master dropped", m_master, 0);
    chk("R10 sck low", m_sck, 0);
    rd(0, CTRL, d); chk("R10 ctrl bit4 cleared", d, 8'h40);
    rd(0, STAT, d); chk("R10 flag set", d, 8'h80);
    rd(0, DATA, d);
    m_ss_n = 1; m_ss_in = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    int seen = 0;
    wr(0, CTRL, 8'h10);
    wr(0, DATA, 8'hAA);
    repeat (40) begin @(negedge clk); if (m_sck) seen++; end
    chk("R12 no sck when disabled", seen, 0);
    rd(0, STAT, d); chk("R12 no flag when disabled", d, 8'h00);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_reserved();
    t_dividers();
    t_xfer(1, 8'hA5, 8'h3C, 1'b0);
    t_xfer(0, 8'h81, 8'h7E, 1'b0);
    t_xfer(0, 8'h00, 8'hFF, 1'b0);
    t_xfer(5, 8'h2B, 8'hD4, 1'b0);
    t_xfer(0, 8'h01, 8'h80, 1'b1);
    t_xfer(1, 8'hC6, 8'h35, 1'b1);
    t_collision();
    t_same_cycle();
    t_irq();
    t_mode_fault();
    t_disabled();
    finish_run();
  end
endmodule